// File: doc/BRIEF.md
# Strobe-Based Register Access Port

This block is the processor-facing side of a peripheral with a small register set and a data queue behind it. A host talks to it over an asynchronous bus: an active-low select, a direction line (high means the host reads), a data strobe that idles high, and two address bits. The block samples select and strobe into its own clock domain through a flop synchronizer and acts on the edges of the synchronized strobe. A rising strobe with the direction line low writes. A falling strobe with the direction line high starts a read, and the bus stays driven until the strobe rises again or the select goes away.

The address and the direction line together pick one of six resources. These are a command write, a status read, a configuration write, a configuration read, a queue push and a queue pop. Address 3 maps to nothing. The eight configuration registers are reached indirectly: the low three bits of the command register form a pointer, and an access at the configuration address goes to the register that pointer names. Accesses at the data address produce single-cycle push or pop pulses toward the queue logic, which lives outside this block. The command and configuration registers leave the block as plain outputs for the logic that uses them.

Top module: `strp_port`

## Requirements
- R1: While the synchronized select is high (inactive), strobe edges cause no register change, no queue pulse and no bus drive.
- R2: A rising strobe with select low, direction low and address 0 loads `bus_in` into the command register.
- R3: A rising strobe with select low, direction low and address 1 loads `bus_in` into configuration register `cmd_out[2:0]` only. Configuration register k sits at `cfg_out[18*k +: 18]`.
- R4: A falling strobe with select low and direction high drives `bus_out` with the selected source and raises `bus_oe`. The sources are `status_in` at address 0, configuration register `cmd_out[2:0]` at address 1, and `fifo_rd_data` at address 2.
- R5: A rising strobe with select low, direction low and address 2 gives exactly one single-cycle `fifo_wr_pulse`, with `fifo_wr_data` equal to the bus value.
- R6: A falling strobe with select low, direction high and address 2 gives exactly one single-cycle `fifo_rd_pulse`. The bus carries the `fifo_rd_data` value that was present at that edge.
- R7: `bus_oe` is low except during a read. It falls when the strobe rises or when the select goes high, whichever is first.
- R8: A write to address 3 changes nothing. A read from address 3 returns zero. A falling strobe with direction low has no effect.
- R9: After reset, the command and all configuration registers are zero, `bus_oe` is low, and both queue pulses are low.
- R10: An effect shows at the outputs after the third rising clock edge following the change of strobe or select, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Asynchronous select, active low |
| rw | input | 1 | Direction: 1 = host reads, 0 = host writes |
| ds | input | 1 | Asynchronous data strobe, idles high |
| addr | input | 2 | Resource address |
| bus_in | input | 18 | Write data from host |
| bus_out | output | 18 | Read data to host |
| bus_oe | output | 1 | Bus output enable (read in progress) |
| status_in | input | 18 | Status word returned at address 0 |
| fifo_rd_data | input | 18 | Head word of the outbound queue |
| fifo_rd_pulse | output | 1 | Single-cycle pop request |
| fifo_wr_pulse | output | 1 | Single-cycle push request |
| fifo_wr_data | output | 18 | Word to push |
| cmd_out | output | 18 | Command register |
| cfg_out | output | 144 | Eight configuration registers, register k at bits 18k+17..18k |

## Verification
The main function is exercised with full write-then-read cycles at every address. Pointer changes between configuration accesses are interleaved, so that a wrong pointer shows up as a register that should not have moved. Strobe toggles with the select inactive, writes to the unmapped address and falling strobes with the direction line low separate real decode from spurious effects. A read cut short by a select release, rather than a strobe rise, separates the two ways a read can end. A per-clock reference model built on event timestamps places every effect exactly three clock edges after its cause, which catches a synchronizer that is one stage short or one stage long.

// File: rtl/strp_pkg.sv
package strp_pkg;
  typedef enum logic [1:0] {
    RES_CTRL = 2'd0,
    RES_CFG  = 2'd1,
    RES_DATA = 2'd2,
    RES_NONE = 2'd3
  } res_e;
endpackage

// File: rtl/strp_sync.sv
module strp_sync #(
  parameter int         W      = 2,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] RST  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RST;
        else if (s == 0) chain_q[s] <= d;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/strp_front.sv
module strp_front (
  input  logic clk,
  input  logic rst_n,
  input  logic ds_s,
  output logic rise,
  output logic fall
);
  logic ds_q, ds_d;

  always_comb begin
    ds_d = ds_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ds_q <= 1'b1;
    else        ds_q <= ds_d;
  end

  assign rise = ds_s & ~ds_q;
  assign fall = ~ds_s & ds_q;

  // R10
  edge_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/strp_regs.sv
module strp_regs
  import strp_pkg::*;
#(
  parameter int DW   = 18,
  parameter int NCFG = 8,
  localparam int PTRW = $clog2(NCFG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [1:0]               addr,
  input  logic [DW-1:0]            wr_data,
  output logic [DW-1:0]            cmd,
  output logic [PTRW-1:0]          ptr,
  output logic [NCFG-1:0][DW-1:0]  cfg,
  output logic                     push,
  output logic [DW-1:0]            push_data
);
  logic [DW-1:0]           cmd_q, cmd_d;
  logic                    push_q, push_d;
  logic [DW-1:0]           pdat_q, pdat_d;
  logic [NCFG-1:0][DW-1:0] cfg_q;
  logic [NCFG-1:0]         cfg_we;
  res_e                    res;

  assign res = res_e'(addr);
  assign ptr = cmd_q[PTRW-1:0];

  always_comb begin
    cmd_d  = cmd_q;
    push_d = 1'b0;
    pdat_d = pdat_q;
    if (wr_stb) begin
      case (res)
        RES_CTRL: cmd_d = wr_data;
        RES_DATA: begin
          push_d = 1'b1;
          pdat_d = wr_data;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      push_q <= 1'b0;
      pdat_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      push_q <= push_d;
      pdat_q <= pdat_d;
    end
  end

  generate
    for (genvar i = 0; i < NCFG; i++) begin : g_cfg
      assign cfg_we[i] = wr_stb && (res == RES_CFG) && (ptr == PTRW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cfg_q[i] <= '0;
        else if (cfg_we[i]) cfg_q[i] <= wr_data;
      end
    end
  endgenerate

  assign cmd       = cmd_q;
  assign cfg       = cfg_q;
  assign push      = push_q;
  assign push_data = pdat_q;

  // R3
  cfg_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && res != RES_CFG) |=> $stable(cfg_q));
  // R5
  push_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |=> !push_q);
endmodule

// File: rtl/strp_rdpath.sv
module strp_rdpath
  import strp_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic          end_stb,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] cfg_sel,
  input  logic [DW-1:0] head,
  output logic [DW-1:0] rdata,
  output logic          oe,
  output logic          pop
);
  logic          oe_q, oe_d;
  logic          pop_q, pop_d;
  logic [DW-1:0] dat_q, dat_d;
  res_e          res;

  assign res = res_e'(addr);

  always_comb begin
    oe_d  = oe_q;
    pop_d = 1'b0;
    dat_d = dat_q;
    if (end_stb) oe_d = 1'b0;
    if (rd_stb) begin
      oe_d = 1'b1;
      case (res)
        RES_CTRL: dat_d = status;
        RES_CFG:  dat_d = cfg_sel;
        RES_DATA: begin
          dat_d = head;
          pop_d = 1'b1;
        end
        default:  dat_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      pop_q <= 1'b0;
      dat_q <= '0;
    end else begin
      oe_q  <= oe_d;
      pop_q <= pop_d;
      dat_q <= dat_d;
    end
  end

  assign rdata = dat_q;
  assign oe    = oe_q;
  assign pop   = pop_q;

  // R6
  pop_with_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_q |-> oe_q);
  // R6
  pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_q |=> !pop_q);
endmodule

// File: rtl/strp_port.sv
module strp_port
  import strp_pkg::*;
#(
  parameter int DW          = 18,
  parameter int NCFG        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               rw,
  input  logic               ds,
  input  logic [1:0]         addr,
  input  logic [DW-1:0]      bus_in,
  output logic [DW-1:0]      bus_out,
  output logic               bus_oe,
  input  logic [DW-1:0]      status_in,
  input  logic [DW-1:0]      fifo_rd_data,
  output logic               fifo_rd_pulse,
  output logic               fifo_wr_pulse,
  output logic [DW-1:0]      fifo_wr_data,
  output logic [DW-1:0]      cmd_out,
  output logic [NCFG*DW-1:0] cfg_out
);
  localparam int PTRW = $clog2(NCFG);

  logic [1:0]              sync_q;
  logic                    cs_hi, ds_s;
  logic                    rise, fall;
  logic                    wr_stb, rd_stb, end_stb;
  logic [PTRW-1:0]         ptr;
  logic [NCFG-1:0][DW-1:0] cfg;

  strp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, ds}), .q(sync_q)
  );
  assign cs_hi = sync_q[1];
  assign ds_s  = sync_q[0];

  strp_front u_front (
    .clk(clk), .rst_n(rst_n), .ds_s(ds_s), .rise(rise), .fall(fall)
  );

  assign wr_stb  = rise & ~cs_hi & ~rw;
  assign rd_stb  = fall & ~cs_hi & rw;
  assign end_stb = rise | cs_hi;

  strp_regs #(.DW(DW), .NCFG(NCFG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(addr), .wr_data(bus_in),
    .cmd(cmd_out), .ptr(ptr), .cfg(cfg),
    .push(fifo_wr_pulse), .push_data(fifo_wr_data)
  );

  strp_rdpath #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .end_stb(end_stb), .addr(addr),
    .status(status_in), .cfg_sel(cfg[ptr]), .head(fifo_rd_data),
    .rdata(bus_out), .oe(bus_oe), .pop(fifo_rd_pulse)
  );

  assign cfg_out = cfg;

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> ($stable(cmd_out) && $stable(cfg_out) && !fifo_wr_pulse));
  // R4
  read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(rw));
  // R5
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_wr_pulse && fifo_rd_pulse));
  // R7
  oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && !rd_stb) |=> !bus_oe);
endmodule

// File: tb/strp_port_test.sv
module strp_port_test;
  localparam int DW  = 18;
  localparam int NC  = 8;
  localparam int LAT = 3;

  typedef enum logic [1:0] {EV_RISE = 2'd1, EV_FALL = 2'd2, EV_DESEL = 2'd3} ev_k;
  typedef struct packed {
    int            due;
    ev_k           kind;
    logic          rw;
    logic [1:0]    addr;
    logic [DW-1:0] data;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rw = 1'b0, ds = 1'b1;
  logic [1:0] addr = '0;
  logic [DW-1:0] bus_in = '0, status_in = '0, fifo_rd_data = '0;
  logic [DW-1:0] bus_out, fifo_wr_data, cmd_out;
  logic bus_oe, fifo_rd_pulse, fifo_wr_pulse;
  logic [NC*DW-1:0] cfg_out;

  strp_port uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .ds(ds), .addr(addr),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .status_in(status_in),
    .fifo_rd_data(fifo_rd_data), .fifo_rd_pulse(fifo_rd_pulse),
    .fifo_wr_pulse(fifo_wr_pulse), .fifo_wr_data(fifo_wr_data),
    .cmd_out(cmd_out), .cfg_out(cfg_out)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  int nchk = 0, nerr = 0;
  int wr_cnt = 0, rd_cnt = 0;
  ev_t evq[$];

  logic [DW-1:0] m_cmd, m_data, m_wdata;
  logic [DW-1:0] m_cfg [NC];
  logic m_oe, m_wr, m_rd;
  logic [NC*DW-1:0] m_flat;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [NC*DW-1:0] act,
                     input logic [NC*DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    m_cmd = '0; m_data = '0; m_wdata = '0;
    m_oe = 1'b0; m_wr = 1'b0; m_rd = 1'b0;
    for (int i = 0; i < NC; i++) m_cfg[i] = '0;
  endtask

  task automatic apply(input ev_t e);
    case (e.kind)
      EV_DESEL: m_oe = 1'b0;
      EV_RISE: begin
        m_oe = 1'b0;
        if (!e.rw) begin
          case (e.addr)
            2'd0: m_cmd = e.data;
            2'd1: m_cfg[m_cmd[2:0]] = e.data;
            2'd2: begin m_wr = 1'b1; m_wdata = e.data; end
            default: ;
          endcase
        end
      end
      EV_FALL: begin
        if (e.rw) begin
          m_oe = 1'b1;
          case (e.addr)
            2'd0: m_data = status_in;
            2'd1: m_data = m_cfg[m_cmd[2:0]];
            2'd2: begin m_data = fifo_rd_data; m_rd = 1'b1; end
            default: m_data = '0;
          endcase
        end
      end
      default: ;
    endcase
  endtask

  // per-clock comparison against the reference model (R7, R9, R10 timing)
  always @(negedge clk) begin
    if (rst_n) begin
      m_wr = 1'b0;
      m_rd = 1'b0;
      while (evq.size() > 0 && evq[0].due == cyc) apply(evq.pop_front());
      for (int i = 0; i < NC; i++) m_flat[i*DW +: DW] = m_cfg[i];
      chk(bus_oe === m_oe, "R7 bus_oe", NC*DW'(bus_oe), NC*DW'(m_oe));
      chk(fifo_wr_pulse === m_wr, "R5 wr pulse", NC*DW'(fifo_wr_pulse), NC*DW'(m_wr));
      chk(fifo_rd_pulse === m_rd, "R6 rd pulse", NC*DW'(fifo_rd_pulse), NC*DW'(m_rd));
      chk(cmd_out === m_cmd, "R2 cmd", NC*DW'(cmd_out), NC*DW'(m_cmd));
      chk(cfg_out === m_flat, "R3 cfg", cfg_out, m_flat);
      if (m_oe) chk(bus_out === m_data, "R4 bus_out", NC*DW'(bus_out), NC*DW'(m_data));
      if (m_wr) chk(fifo_wr_data === m_wdata, "R5 wr data", NC*DW'(fifo_wr_data), NC*DW'(m_wdata));
      if (fifo_wr_pulse) wr_cnt++;
      if (fifo_rd_pulse) rd_cnt++;
    end
  end

  task automatic push_ev(input ev_k k);
    ev_t e;
    e.due = cyc + LAT; e.kind = k; e.rw = rw; e.addr = addr; e.data = bus_in;
    evq.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); cs_n = 1'b0; rw = 1'b0; addr = a; bus_in = d;
    idle(4); ds = 1'b0;
    idle(4); ds = 1'b1; push_ev(EV_RISE);
    idle(4); cs_n = 1'b1; push_ev(EV_DESEL);
    idle(4);
  endtask

  task automatic host_read(input logic [1:0] a, output logic [DW-1:0] got);
    @(negedge clk); cs_n = 1'b0; rw = 1'b1; addr = a;
    idle(4); ds = 1'b0; push_ev(EV_FALL);
    idle(5); got = bus_out;
    ds = 1'b1; push_ev(EV_RISE);
    idle(4); cs_n = 1'b1; push_ev(EV_DESEL);
    idle(4);
  endtask

  logic [DW-1:0] got;
  int w0, r0;

  initial begin
    model_reset();
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(cmd_out === '0 && cfg_out === '0, "R9 regs zero", cfg_out, '0);
    chk(!bus_oe && !fifo_rd_pulse && !fifo_wr_pulse, "R9 outputs idle",
        NC*DW'({bus_oe, fifo_rd_pulse, fifo_wr_pulse}), '0);

    // R2: command write
    host_write(2'd0, 18'h2A5A3);
    chk(cmd_out === 18'h2A5A3, "R2 cmd load", NC*DW'(cmd_out), NC*DW'(18'h2A5A3));

    // R3: pointer-selected configuration writes
    host_write(2'd0, 18'h00003);
    host_write(2'd1, 18'h1ABCD);
    host_write(2'd0, 18'h00005);
    host_write(2'd1, 18'h03210);
    chk(cfg_out[3*DW +: DW] === 18'h1ABCD, "R3 cfg3", NC*DW'(cfg_out[3*DW +: DW]), NC*DW'(18'h1ABCD));
    chk(cfg_out[5*DW +: DW] === 18'h03210, "R3 cfg5", NC*DW'(cfg_out[5*DW +: DW]), NC*DW'(18'h03210));
    chk(cfg_out[4*DW +: DW] === '0, "R3 cfg4 untouched", NC*DW'(cfg_out[4*DW +: DW]), '0);

    // R4: reads from status and configuration
    status_in = 18'h3C0F1;
    host_read(2'd0, got);
    chk(got === 18'h3C0F1, "R4 status read", NC*DW'(got), NC*DW'(18'h3C0F1));
    host_write(2'd0, 18'h00003);
    host_read(2'd1, got);
    chk(got === 18'h1ABCD, "R4 cfg read via pointer", NC*DW'(got), NC*DW'(18'h1ABCD));

    // R5: queue push
    w0 = wr_cnt;
    host_write(2'd2, 18'h15555);
    chk(wr_cnt - w0 == 1, "R5 one push", NC*DW'(wr_cnt - w0), NC*DW'(1));

    // R6: queue pop
    r0 = rd_cnt;
    fifo_rd_data = 18'h2F00D;
    host_read(2'd2, got);
    chk(rd_cnt - r0 == 1, "R6 one pop", NC*DW'(rd_cnt - r0), NC*DW'(1));
    chk(got === 18'h2F00D, "R6 pop data", NC*DW'(got), NC*DW'(18'h2F00D));

    // R8: unmapped address and falling strobe during a write
    host_write(2'd3, 18'h3FFFF);
    chk(cmd_out === 18'h00003 && cfg_out[3*DW +: DW] === 18'h1ABCD, "R8 addr3 write ignored",
        NC*DW'(cmd_out), NC*DW'(18'h00003));
    host_read(2'd3, got);
    chk(got === '0, "R8 addr3 reads zero", NC*DW'(got), '0);

    // R1: strobe toggles while select inactive
    w0 = wr_cnt; r0 = rd_cnt;
    @(negedge clk); rw = 1'b0; addr = 2'd0; bus_in = 18'h12345;
    ds = 1'b0; idle(4); ds = 1'b1; idle(4);
    rw = 1'b1; addr = 2'd2; ds = 1'b0; idle(4); ds = 1'b1; idle(4);
    chk(cmd_out === 18'h00003, "R1 cmd unchanged", NC*DW'(cmd_out), NC*DW'(18'h00003));
    chk(wr_cnt == w0 && rd_cnt == r0 && !bus_oe, "R1 no pulses",
        NC*DW'(wr_cnt - w0 + rd_cnt - r0), '0);

    // R7: read ended by select release while strobe still low
    @(negedge clk); cs_n = 1'b0; rw = 1'b1; addr = 2'd0;
    idle(4); ds = 1'b0; push_ev(EV_FALL);
    idle(4);
    chk(bus_oe === 1'b1, "R7 oe during read", NC*DW'(bus_oe), NC*DW'(1));
    cs_n = 1'b1; push_ev(EV_DESEL);
    idle(4);
    chk(bus_oe === 1'b0, "R7 oe off after deselect", NC*DW'(bus_oe), '0);
    ds = 1'b1; idle(4);

    // R10: write effect appears on the third clock edge, not earlier
    @(negedge clk); cs_n = 1'b0; rw = 1'b0; addr = 2'd0; bus_in = 18'h0ACE1;
    idle(4); ds = 1'b0; idle(4);
    ds = 1'b1; push_ev(EV_RISE);
    idle(2);
    chk(cmd_out === 18'h00003, "R10 not yet at edge 2", NC*DW'(cmd_out), NC*DW'(18'h00003));
    idle(1);
    chk(cmd_out === 18'h0ACE1, "R10 visible at edge 3", NC*DW'(cmd_out), NC*DW'(18'h0ACE1));
    idle(1); cs_n = 1'b1; push_ev(EV_DESEL); idle(5);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule